// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is one output cell placed after the OR gate of a sum-of-products array. It takes the OR result, optionally stores it in a D flip-flop, selects either the stored value or the live sum, can invert that choice, and drives a pin model that has a separate data value and drive enable. It also returns a feedback value to the array. Sequential designs such as state machines are built by feeding the flop output back into the product terms.

Four static configuration inputs set the cell's output style. With them, one cell can act as a plain combinational output, a registered output with or without feedback, a bidirectional pin, or a buried register with no pin drive. The drive enable is either held on or taken from a dedicated product-term input. Reset is synchronous and clears the flop to 0.

Top module: `omc_cell`

## Requirements
- R1: On each rising edge of `clk` with `rst` low, the flop stores `sumIn`. In a registered style the new value appears on `feedback` after that edge and stays unchanged until the next edge, even if `sumIn` changes in between.
- R2: In combinational style (`cfgRegistered`=0, `cfgBuried`=0), `pinOut` equals `sumIn` XOR `cfgInvert` in the same cycle, with no clock edge needed.
- R3: In a registered style (`cfgRegistered`=1 or `cfgBuried`=1), `pinOut` equals the flop value XOR `cfgInvert`.
- R4: `cfgInvert` affects only `pinOut`. The flop stores `sumIn` uninverted, and in registered styles `feedback` carries the uninverted flop value.
- R5: When `cfgBuried`=0, `pinOe` is 1 if `cfgOeFromTerm`=0, and `pinOe` equals `oeTerm` if `cfgOeFromTerm`=1.
- R6: When `cfgBuried`=1, `pinOe` is 0 whatever `cfgOeFromTerm` and `oeTerm` are. The flop keeps updating, and `feedback` carries its value.
- R7: In registered style without burying, `feedback` is the flop value whatever `pinOe` and `pinIn` are.
- R8: In combinational style with `pinOe`=1, `feedback` equals `pinOut`.
- R9: In combinational style with `pinOe`=0, `feedback` equals `pinIn`.
- R10: If `rst` is high at a rising edge, the flop clears to 0 whatever `sumIn` is. Between edges, `rst` has no effect on the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flop samples on the rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the flop |
| sumIn | input | 1 | OR-gate result from the product-term array |
| cfgRegistered | input | 1 | 1 selects the flop output for the pin, 0 selects the live sum |
| cfgInvert | input | 1 | 1 inverts the selected value on its way to the pin |
| cfgOeFromTerm | input | 1 | 1 takes the drive enable from `oeTerm`, 0 holds it on |
| cfgBuried | input | 1 | 1 makes the cell a buried register: pin never driven |
| oeTerm | input | 1 | Product term used as the drive enable |
| pinIn | input | 1 | Value seen on the pin when it is not driven |
| pinOut | output | 1 | Value the cell drives onto the pin |
| pinOe | output | 1 | Drive enable for the pin |
| feedback | output | 1 | Value returned to the array |

## Verification
`pinOut`, `pinOe` and combinational-style `feedback` follow the inputs within the same cycle. The flop-based results (registered `pinOut` and `feedback`) change only one rising edge after `sumIn` or `rst` is presented. The bench applies each stimulus on the falling edge and samples 1 ns later, before the next rising edge. So every sample shows the combinational response to the new inputs together with the flop value captured at the previous edge. The expected values in the vector table are worked out step by step from the flop contents left by the earlier rows. One directed step changes `sumIn` between edges to show that registered feedback holds until the next edge.

// File: rtl/omc_pkg.sv
package omc_pkg;

  // Output style resolved from the configuration inputs
  typedef enum logic [1:0] {
    STYLE_COMB   = 2'd0,
    STYLE_REG    = 2'd1,
    STYLE_BURIED = 2'd2
  } cellStyle_t;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic useReg;     // pin value taken from the flop
    logic flip;       // invert pin value
    logic drive;      // pin drive enable
    logic fbFromReg;  // feedback taken from the flop
  } cellStrobe_t;

endpackage

// File: rtl/omc_ctrl.sv
module omc_ctrl
  import omc_pkg::*;
(
  input  logic        cfgRegistered,
  input  logic        cfgInvert,
  input  logic        cfgOeFromTerm,
  input  logic        cfgBuried,
  input  logic        oeTerm,
  output cellStrobe_t strobe
);

  cellStyle_t style;
  logic       enableReq;

  // Burying overrides the select bit: a buried cell is always registered
  always_comb begin
    if (cfgBuried)          style = STYLE_BURIED;
    else if (cfgRegistered) style = STYLE_REG;
    else                    style = STYLE_COMB;
  end

  // Drive request before the buried override
  always_comb begin
    enableReq = cfgOeFromTerm ? oeTerm : 1'b1;
  end

  always_comb begin
    strobe.flip = cfgInvert;
    unique case (style)
      STYLE_COMB: begin
        strobe.useReg    = 1'b0;
        strobe.fbFromReg = 1'b0;
        strobe.drive     = enableReq;
      end
      STYLE_REG: begin
        strobe.useReg    = 1'b1;
        strobe.fbFromReg = 1'b1;
        strobe.drive     = enableReq;
      end
      STYLE_BURIED: begin
        strobe.useReg    = 1'b1;
        strobe.fbFromReg = 1'b1;
        strobe.drive     = 1'b0;
      end
      default: begin
        strobe.useReg    = 1'b0;
        strobe.fbFromReg = 1'b0;
        strobe.drive     = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/omc_datapath.sv
module omc_datapath
  import omc_pkg::*;
#(
  parameter logic CLEAR_LEVEL = 1'b0
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        sumIn,
  input  logic        pinIn,
  input  cellStrobe_t strobe,
  output logic        pinOut,
  output logic        pinOe,
  output logic        feedback
);

  logic stateQ;
  logic selected;
  logic pinValue;

  // Storage element: synchronous clear has priority over capture
  always_ff @(posedge clk) begin
    if (rst) stateQ <= CLEAR_LEVEL;
    else     stateQ <= sumIn;
  end

  always_comb begin
    selected = strobe.useReg ? stateQ : sumIn;
    pinOut   = selected ^ strobe.flip;
    pinOe    = strobe.drive;
  end

  // Level on the pin model: own drive when enabled, else external value
  always_comb begin
    pinValue = strobe.drive ? pinOut : pinIn;
  end

  always_comb begin
    feedback = strobe.fbFromReg ? stateQ : pinValue;
  end

endmodule

// File: rtl/omc_cell.sv
module omc_cell
  import omc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sumIn,
  input  logic cfgRegistered,
  input  logic cfgInvert,
  input  logic cfgOeFromTerm,
  input  logic cfgBuried,
  input  logic oeTerm,
  input  logic pinIn,
  output logic pinOut,
  output logic pinOe,
  output logic feedback
);

  cellStrobe_t strobe;

  omc_ctrl i_ctrl (
    .cfgRegistered (cfgRegistered),
    .cfgInvert     (cfgInvert),
    .cfgOeFromTerm (cfgOeFromTerm),
    .cfgBuried     (cfgBuried),
    .oeTerm        (oeTerm),
    .strobe        (strobe)
  );

  omc_datapath #(.CLEAR_LEVEL(1'b0)) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .sumIn    (sumIn),
    .pinIn    (pinIn),
    .strobe   (strobe),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .feedback (feedback)
  );

endmodule

// File: rtl/omc_cell_chk.sv
module omc_cell_chk (
  input logic clk,
  input logic rst,
  input logic sumIn,
  input logic cfgRegistered,
  input logic cfgInvert,
  input logic cfgOeFromTerm,
  input logic cfgBuried,
  input logic oeTerm,
  input logic pinIn,
  input logic pinOut,
  input logic pinOe,
  input logic feedback
);

  logic regStyle;
  assign regStyle = cfgRegistered || cfgBuried;

  // R1
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (regStyle && $past(regStyle) && !$past(rst)) |-> (feedback == $past(sumIn)));

  // R10
  sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (regStyle && $past(rst)) |-> (feedback == 1'b0));

  // R2
  comb_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (!regStyle) |-> (pinOut == (sumIn ^ cfgInvert)));

  // R3
  reg_pin_chk: assert property (@(posedge clk) disable iff (rst)
    regStyle |-> (pinOut == (feedback ^ cfgInvert)));

  // R5
  oe_select_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfgBuried) |-> (pinOe == (cfgOeFromTerm ? oeTerm : 1'b1)));

  // R6
  buried_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfgBuried |-> !pinOe);

  // R8
  comb_fb_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!regStyle && pinOe) |-> (feedback == pinOut));

  // R9
  comb_fb_input_chk: assert property (@(posedge clk) disable iff (rst)
    (!regStyle && !pinOe) |-> (feedback == pinIn));

endmodule

bind omc_cell omc_cell_chk i_omcCellChk (
  .clk           (clk),
  .rst           (rst),
  .sumIn         (sumIn),
  .cfgRegistered (cfgRegistered),
  .cfgInvert     (cfgInvert),
  .cfgOeFromTerm (cfgOeFromTerm),
  .cfgBuried     (cfgBuried),
  .oeTerm        (oeTerm),
  .pinIn         (pinIn),
  .pinOut        (pinOut),
  .pinOe         (pinOe),
  .feedback      (feedback)
);

// File: tb/test_omc_cell.sv
module test_omc_cell;

  logic clk = 1'b0;
  logic rst, sumIn, cfgRegistered, cfgInvert, cfgOeFromTerm, cfgBuried, oeTerm, pinIn;
  logic pinOut, pinOe, feedback;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  omc_cell i_omc_cell (
    .clk(clk), .rst(rst), .sumIn(sumIn), .cfgRegistered(cfgRegistered),
    .cfgInvert(cfgInvert), .cfgOeFromTerm(cfgOeFromTerm), .cfgBuried(cfgBuried),
    .oeTerm(oeTerm), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .feedback(feedback)
  );

  // Vector: {rst,sum,reg,inv,oeSel,buried,oeTerm,pinIn, expOut,expOe,expFb}
  localparam int NVEC = 14;
  localparam logic [10:0] VEC [NVEC] = '{
    11'b0_1_0_0_0_0_0_0_1_1_1, // comb, drive on, fb = pin value (R2 R8), flop<-1
    11'b0_0_0_1_0_0_0_0_1_1_1, // comb inverted (R4), flop<-0
    11'b0_1_0_0_1_0_0_1_1_0_1, // comb, term disables, fb = pinIn 1 (R5 R9), flop<-1
    11'b0_1_0_0_1_0_0_0_1_0_0, // fb = pinIn 0 (R9), flop<-1
    11'b0_0_1_0_0_0_0_0_1_1_1, // registered shows flop 1 (R1 R3), flop<-0
    11'b0_1_1_1_0_0_0_0_1_1_0, // flop 0 inverted to pin, fb true 0 (R4), flop<-1
    11'b0_0_1_1_0_0_0_0_0_1_1, // flop 1 inverted, fb 1 (R4), flop<-0
    11'b0_1_1_0_1_0_0_1_0_0_0, // reg, pin off, pinIn ignored (R7), flop<-1
    11'b0_1_1_0_1_0_1_0_1_1_1, // reg, term enables (R5 R7), flop<-1
    11'b1_1_1_0_0_0_0_0_1_1_1, // reset asserted, flop still 1 before edge (R10), flop<-0
    11'b0_1_0_0_0_1_1_1_0_0_0, // buried, flop cleared, no drive (R6 R10), flop<-1
    11'b0_0_0_0_1_1_1_0_1_0_1, // buried keeps updating, term ignored (R6), flop<-0
    11'b0_1_1_0_0_0_0_0_0_1_0, // registered after buried (R3), flop<-1
    11'b0_0_0_1_1_0_1_0_1_1_1  // comb inverted, term enables (R2 R8)
  };

  task automatic check(input string tag, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    endRun();
  end

  initial begin
    rst = 1'b1; sumIn = 1'b1; cfgRegistered = 1'b1; cfgInvert = 1'b0;
    cfgOeFromTerm = 1'b0; cfgBuried = 1'b0; oeTerm = 1'b0; pinIn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    // R10: reset held across edges clears the flop even with sumIn = 1
    check("R10 reset fb", feedback, 1'b0);
    check("R10 reset pinOut", pinOut, 1'b0);
    check("R5 reset pinOe", pinOe, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {rst, sumIn, cfgRegistered, cfgInvert, cfgOeFromTerm, cfgBuried, oeTerm, pinIn} = VEC[i][10:3];
      #1;
      check((cfgRegistered || cfgBuried) ? "R3 pinOut" : "R2 pinOut", pinOut, VEC[i][2]);
      check(cfgBuried ? "R6 pinOe" : "R5 pinOe", pinOe, VEC[i][1]);
      if (cfgBuried)          check("R6 feedback", feedback, VEC[i][0]);
      else if (cfgRegistered) check("R7 feedback", feedback, VEC[i][0]);
      else if (pinOe)         check("R8 feedback", feedback, VEC[i][0]);
      else                    check("R9 feedback", feedback, VEC[i][0]);
    end

    // R1: capture on the edge, hold between edges
    @(negedge clk);
    rst = 1'b0; cfgRegistered = 1'b1; cfgBuried = 1'b0; cfgInvert = 1'b0;
    cfgOeFromTerm = 1'b0; sumIn = 1'b1;
    @(negedge clk); #1;
    check("R1 captured", feedback, 1'b1);
    sumIn = 1'b0; #1;
    check("R1 hold between edges", feedback, 1'b1);
    check("R3 hold pin", pinOut, 1'b1);
    @(negedge clk); #1;
    check("R1 captured zero", feedback, 1'b0);

    // R10: reset raised mid-cycle does nothing until the edge
    sumIn = 1'b1;
    @(negedge clk); #1;
    check("R1 captured one", feedback, 1'b1);
    rst = 1'b1; #1;
    check("R10 no effect before edge", feedback, 1'b1);
    @(negedge clk); #1;
    check("R10 cleared at edge", feedback, 1'b0);

    endRun();
  end

endmodule